// File: doc/BRIEF.md
# Adaptive JTAG Clock Pacer

This block is the probe-side engine that clocks a target's test access port. It runs on the probe's own sampling clock and produces TCK, TMS and TDI toward the target, while it takes back TDO and the target's returned clock (RTCK). A caller hands it one shift request: a bit count, a vector of TMS bits and a vector of TDI bits, shifted least significant bit first. The block returns the TDO bit captured at each rising TCK edge and pulses `done` once the last bit has left.

Two pacing modes exist. In fixed mode every TCK half period lasts a programmed number of sampling-clock cycles and RTCK is not looked at. In adaptive mode each TCK edge waits for the target to echo the previous edge on RTCK. RTCK first passes a two-flop synchronizer, then a programmable guard delay is counted before the next edge. A programmable timeout ends the transfer with an error flag if the echo never arrives. TCK is held low whenever the block is idle.

Top module: `tck_pacer`

## Requirements
- R1: After reset and whenever `busy` is 0, `tck` is 0. Reset also clears `busy`, `done`, `timeoutErr`, `tms` and `tdi`.
- R2: While idle, a `reqValid` pulse with `reqCount` in 1..MAX_BITS (16 by default) is accepted at that clock edge, and `busy` reads 1 from then on. A count of 0 or above MAX_BITS is ignored, and any request made while `busy` is 1 is ignored.
- R3: In fixed mode (`adaptive`=0), with H = max(`halfPeriod`,1) and the accept edge at cycle E0, rise i of `tck` happens at E0+H*(2i+1) and fall i at E0+2H*(i+1). Both `rtck` and `timeoutLimit` have no effect in this mode.
- R4: In adaptive mode a rising `tck` edge is made only while the synchronized `rtck` is 0, and a falling edge only while it is 1. The synchronizer has two stages.
- R5: In adaptive mode, with G = max(`minGap`,1): if the echoed `rtck` level is first sampled at clock edge k, the next `tck` edge comes at edge k+1+G. The first rise after accept (with `rtck` already low) comes at E0+G.
- R6: Bit i of `reqTms`/`reqTdi` (bit 0 first) appears on `tms`/`tdi` at the accept edge for i=0, or at fall i-1 otherwise. It then stays stable while `tck` is high.
- R7: The `tdo` level seen at the clock edge of rise i is stored in `tdoBits[i]`. `tdoBits` is cleared on accept, so bits at index `reqCount` and above read 0.
- R8: `done` is a one-cycle pulse at the clock edge of the final fall of `tck`, and `busy` drops at that same edge.
- R9: In adaptive mode with `timeoutLimit` T nonzero, if the synchronized `rtck` has not matched for T cycles after a `tck` edge at E, then at edge E+T `tck` is forced low, `busy` drops, no `done` is given and `timeoutErr` is set. The flag is held until the next accepted request. A T of 0 disables the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| adaptive | input | 1 | 1 = pace from RTCK, 0 = fixed divider |
| halfPeriod | input | CYC_W | Fixed-mode half period in cycles (0 acts as 1) |
| minGap | input | CYC_W | Adaptive guard cycles after echo (0 acts as 1) |
| timeoutLimit | input | TO_W | Adaptive echo timeout in cycles, 0 = off |
| reqValid | input | 1 | Shift request strobe |
| reqCount | input | CNT_W | Number of bits to shift |
| reqTms | input | MAX_BITS | TMS bits, bit 0 first |
| reqTdi | input | MAX_BITS | TDI bits, bit 0 first |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeoutErr | output | 1 | Sticky echo-timeout flag |
| tdoBits | output | MAX_BITS | Captured TDO bits |
| tck | output | 1 | Test clock to target |
| tms | output | 1 | Test mode select to target |
| tdi | output | 1 | Test data to target |
| tdo | input | 1 | Test data from target |
| rtck | input | 1 | Returned clock from target |

## Verification
Each `tck` edge is due at a cycle fixed by arithmetic. In fixed mode it falls at an odd or even multiple of H after the accept edge. In adaptive mode each half period is the bench's echo latency plus one plus G. An abort comes exactly T cycles after the edge whose echo is withheld, and `done` comes on the cycle of the last fall. The bench stamps every `tck` transition with a cycle count taken on the falling clock edge and compares each stamp with the computed cycle. It samples `tms`, `tdi`, `done` and `timeoutErr` in that same half cycle. Before it reads `tdoBits` and the flags, it waits one further half cycle after `busy` drops.

// File: rtl/tck_pacer_pkg.sv
package tck_pacer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH
  } phase_e;

  // strobes from control to datapath, at most one of rise/fall/abort per cycle
  typedef struct packed {
    logic load;
    logic rise;
    logic fall;
    logic abort;
  } strobe_t;

endpackage

// File: rtl/tck_pacer_sync.sv
module tck_pacer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/tck_pacer_ctrl.sv
module tck_pacer_ctrl
  import tck_pacer_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int CYC_W    = 8,
  parameter int TO_W     = 10,
  parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             adaptive,
  input  logic [CYC_W-1:0] halfPeriod,
  input  logic [CYC_W-1:0] minGap,
  input  logic [TO_W-1:0]  timeoutLimit,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] reqCount,
  input  logic             rtckSync,
  input  logic             lastBit,
  output strobe_t          stb,
  output logic             busy,
  output logic             done,
  output logic             timeoutErr
);

  localparam int CW1 = CYC_W + 1;

  phase_e           phase;
  logic [CYC_W-1:0] cnt;
  logic [TO_W-1:0]  waitCnt;

  logic             reqOk;
  logic             inPhase;
  logic             wantHigh;
  logic             matched;
  logic [CYC_W-1:0] target;
  logic [CW1-1:0]   cntNext;
  logic             reach;
  logic             fire;
  logic             timedOut;

  assign reqOk    = reqValid && (reqCount != '0) && (reqCount <= CNT_W'(MAX_BITS));
  assign inPhase  = (phase != PH_IDLE);
  assign wantHigh = (phase == PH_HIGH);
  // fixed mode never waits on the echo
  assign matched  = !adaptive || (rtckSync == wantHigh);
  assign target   = adaptive ? minGap : halfPeriod;
  assign cntNext  = {1'b0, cnt} + CW1'(1);
  assign reach    = cntNext >= {1'b0, target};
  assign fire     = inPhase && matched && reach;
  assign timedOut = adaptive && (timeoutLimit != '0) && !matched
                    && (waitCnt == timeoutLimit - TO_W'(1));

  always_comb begin
    stb       = '0;
    stb.load  = (phase == PH_IDLE) && reqOk;
    stb.rise  = fire && (phase == PH_LOW);
    stb.fall  = fire && wantHigh;
    stb.abort = inPhase && timedOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      waitCnt    <= '0;
      done       <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (stb.load) begin
            phase      <= PH_LOW;
            cnt        <= '0;
            waitCnt    <= '0;
            timeoutErr <= 1'b0;
          end
        end
        default: begin
          if (stb.abort) begin
            phase      <= PH_IDLE;
            timeoutErr <= 1'b1;
          end else if (fire) begin
            cnt     <= '0;
            waitCnt <= '0;
            if (phase == PH_LOW) begin
              phase <= PH_HIGH;
            end else if (lastBit) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end else begin
              phase <= PH_LOW;
            end
          end else if (matched) begin
            cnt <= cntNext[CYC_W-1:0];
          end else begin
            waitCnt <= waitCnt + TO_W'(1);
          end
        end
      endcase
    end
  end

  assign busy = inPhase;

endmodule

// File: rtl/tck_pacer_dp.sv
module tck_pacer_dp
  import tck_pacer_pkg::*;
#(
  parameter int MAX_BITS    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [CNT_W-1:0]    reqCount,
  input  logic [MAX_BITS-1:0] reqTms,
  input  logic [MAX_BITS-1:0] reqTdi,
  input  logic                rtck,
  input  logic                tdo,
  output logic                tck,
  output logic                tms,
  output logic                tdi,
  output logic [MAX_BITS-1:0] tdoBits,
  output logic                rtckSync,
  output logic                lastBit
);

  localparam int IDX_W = $clog2(MAX_BITS);

  logic [MAX_BITS-1:0] tmsReg;
  logic [MAX_BITS-1:0] tdiReg;
  logic [IDX_W-1:0]    bitIdx;
  logic [IDX_W-1:0]    lastIdx;
  logic [IDX_W-1:0]    nextIdx;

  assign nextIdx = bitIdx + IDX_W'(1);
  assign lastBit = (bitIdx == lastIdx);

  tck_pacer_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(rtck),
    .syncOut(rtckSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tck     <= 1'b0;
      tms     <= 1'b0;
      tdi     <= 1'b0;
      tmsReg  <= '0;
      tdiReg  <= '0;
      bitIdx  <= '0;
      lastIdx <= '0;
    end else if (stb.load) begin
      tck     <= 1'b0;
      tmsReg  <= reqTms;
      tdiReg  <= reqTdi;
      tms     <= reqTms[0];
      tdi     <= reqTdi[0];
      bitIdx  <= '0;
      lastIdx <= IDX_W'(reqCount - CNT_W'(1));
    end else if (stb.rise) begin
      tck <= 1'b1;
    end else if (stb.fall) begin
      tck <= 1'b0;
      if (!lastBit) begin
        bitIdx <= nextIdx;
        tms    <= tmsReg[nextIdx];
        tdi    <= tdiReg[nextIdx];
      end
    end else if (stb.abort) begin
      tck <= 1'b0;
    end
  end

  // one capture flop per bit position
  for (genvar g = 0; g < MAX_BITS; g++) begin : gCap
    logic capQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  capQ <= 1'b0;
      else if (stb.load)                          capQ <= 1'b0;
      else if (stb.rise && bitIdx == IDX_W'(g))   capQ <= tdo;
    end
    assign tdoBits[g] = capQ;
  end

endmodule

// File: rtl/tck_pacer.sv
module tck_pacer
  import tck_pacer_pkg::*;
#(
  parameter int MAX_BITS    = 16,
  parameter int CYC_W       = 8,
  parameter int TO_W        = 10,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                adaptive,
  input  logic [CYC_W-1:0]    halfPeriod,
  input  logic [CYC_W-1:0]    minGap,
  input  logic [TO_W-1:0]     timeoutLimit,
  input  logic                reqValid,
  input  logic [CNT_W-1:0]    reqCount,
  input  logic [MAX_BITS-1:0] reqTms,
  input  logic [MAX_BITS-1:0] reqTdi,
  output logic                busy,
  output logic                done,
  output logic                timeoutErr,
  output logic [MAX_BITS-1:0] tdoBits,
  output logic                tck,
  output logic                tms,
  output logic                tdi,
  input  logic                tdo,
  input  logic                rtck
);

  strobe_t stb;
  logic    rtckSync;
  logic    lastBit;

  tck_pacer_ctrl #(
    .MAX_BITS(MAX_BITS), .CYC_W(CYC_W), .TO_W(TO_W), .CNT_W(CNT_W)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .adaptive    (adaptive),
    .halfPeriod  (halfPeriod),
    .minGap      (minGap),
    .timeoutLimit(timeoutLimit),
    .reqValid    (reqValid),
    .reqCount    (reqCount),
    .rtckSync    (rtckSync),
    .lastBit     (lastBit),
    .stb         (stb),
    .busy        (busy),
    .done        (done),
    .timeoutErr  (timeoutErr)
  );

  tck_pacer_dp #(
    .MAX_BITS(MAX_BITS), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqCount(reqCount),
    .reqTms  (reqTms),
    .reqTdi  (reqTdi),
    .rtck    (rtck),
    .tdo     (tdo),
    .tck     (tck),
    .tms     (tms),
    .tdi     (tdi),
    .tdoBits (tdoBits),
    .rtckSync(rtckSync),
    .lastBit (lastBit)
  );

endmodule

// File: rtl/tck_pacer_chk.sv
module tck_pacer_chk (
  input logic clk,
  input logic rstN,
  input logic adaptive,
  input logic tck,
  input logic tms,
  input logic tdi,
  input logic busy,
  input logic done,
  input logic timeoutErr,
  input logic rtckSync
);

  AST_IDLE_TCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !tck); // R1

  AST_RISE_AFTER_ECHO_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(tck) && $past(adaptive)) |-> !$past(rtckSync)); // R4

  AST_FALL_AFTER_ECHO_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(tck) && $past(adaptive) && $past(busy) && busy == 1'b0 && !timeoutErr)
      |-> $past(rtckSync)); // R4

  AST_FALL_MID_ECHO_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(tck) && $past(adaptive) && busy) |-> $past(rtckSync)); // R4

  AST_BITS_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    tck |-> ($stable(tms) && $stable(tdi))); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy && !tck)); // R8

  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> !done); // R9

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> (!busy && !tck && $past(busy))); // R9

endmodule

bind tck_pacer tck_pacer_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .adaptive  (adaptive),
  .tck       (tck),
  .tms       (tms),
  .tdi       (tdi),
  .busy      (busy),
  .done      (done),
  .timeoutErr(timeoutErr),
  .rtckSync  (rtckSync)
);

// File: tb/test_tck_pacer.sv
module test_tck_pacer;

  localparam int MAX_BITS = 16;
  localparam int CYC_W    = 8;
  localparam int TO_W     = 10;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                adaptive = 1'b0;
  logic [CYC_W-1:0]    halfPeriod = '0;
  logic [CYC_W-1:0]    minGap = '0;
  logic [TO_W-1:0]     timeoutLimit = '0;
  logic                reqValid = 1'b0;
  logic [CNT_W-1:0]    reqCount = '0;
  logic [MAX_BITS-1:0] reqTms = '0;
  logic [MAX_BITS-1:0] reqTdi = '0;
  logic                busy, done, timeoutErr;
  logic [MAX_BITS-1:0] tdoBits;
  logic                tck, tms, tdi;
  logic                tdo = 1'b0;
  logic                rtck;

  // target model state
  logic [3:0]          rtckPipe = '0;
  int                  echoLen = 1;
  logic                rtckStuck = 1'b0;
  logic                stuckVal = 1'b0;
  logic [MAX_BITS-1:0] tdoPat = '0;

  int nCmp = 0;
  int nBad = 0;
  int cyc = 0;

  // monitor records
  int   riseT [32];
  int   fallT [32];
  logic capTms [32];
  logic capTdi [32];
  int   nRise, nFall, doneSeen, doneT;
  logic prevTck = 1'b0;

  always #2 clk = ~clk;

  tck_pacer i_tck_pacer (
    .clk(clk), .rstN(rstN), .adaptive(adaptive), .halfPeriod(halfPeriod),
    .minGap(minGap), .timeoutLimit(timeoutLimit), .reqValid(reqValid),
    .reqCount(reqCount), .reqTms(reqTms), .reqTdi(reqTdi), .busy(busy),
    .done(done), .timeoutErr(timeoutErr), .tdoBits(tdoBits), .tck(tck),
    .tms(tms), .tdi(tdi), .tdo(tdo), .rtck(rtck)
  );

  assign rtck = rtckStuck ? stuckVal : rtckPipe[echoLen-1];

  always @(posedge clk) cyc <= cyc + 1;

  // target echo: rtck follows tck through echoLen falling-edge stages
  always @(negedge clk) rtckPipe <= {rtckPipe[2:0], tck};

  always @(negedge clk) begin
    if (tck && !prevTck) begin
      riseT[nRise]  = cyc;
      capTms[nRise] = tms;
      capTdi[nRise] = tdi;
      nRise++;
    end
    if (!tck && prevTck) begin
      fallT[nFall] = cyc;
      nFall++;
      if (nRise < MAX_BITS) tdo = tdoPat[nRise];
    end
    if (done) begin
      doneSeen++;
      doneT = cyc;
    end
    prevTck = tck;
  end

  task automatic check(input string what, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic logic [MAX_BITS-1:0] pat(input int seed);
    int v;
    v = (seed * 40503 + 12345) ^ (seed << 7);
    return v[MAX_BITS-1:0];
  endfunction

  // one transfer; abortAt>0 means an abort is expected at rise0+abortAt
  task automatic runXfer(input logic adp, input int hp, input int gap, input int echo,
                         input int tmo, input int n, input int seed,
                         input logic poke, input int abortAt);
    int e0, g, h, ha, expR, expF;
    logic [MAX_BITS-1:0] pt, pd;
    logic [31:0] mask;
    @(negedge clk);
    adaptive     = adp;
    halfPeriod   = CYC_W'(hp);
    minGap       = CYC_W'(gap);
    timeoutLimit = TO_W'(tmo);
    echoLen      = echo;
    rtckStuck    = !adp;
    stuckVal     = 1'b1;
    pt = pat(seed); pd = pat(seed + 101); tdoPat = pat(seed + 202);
    tdo = tdoPat[0];
    repeat (12) @(negedge clk);
    nRise = 0; nFall = 0; doneSeen = 0; doneT = -1;
    reqValid = 1'b1; reqCount = CNT_W'(n); reqTms = pt; reqTdi = pd;
    @(negedge clk);
    reqValid = 1'b0;
    e0 = cyc;
    check("R2 busy after accept", int'(busy), 1);
    check("R9 error cleared on accept", int'(timeoutErr), 0);
    check("R6 first tms at accept", int'(tms), int'(pt[0]));
    if (poke) begin
      reqValid = 1'b1; reqCount = CNT_W'(1); reqTms = ~pt; reqTdi = ~pd;
      @(negedge clk);
      reqValid = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    g  = (gap == 0) ? 1 : gap;
    h  = (hp == 0) ? 1 : hp;
    ha = echo + 1 + g;
    if (abortAt > 0) begin
      check("R9 one rise before abort", nRise, 1);
      check("R9 abort edge", fallT[0], riseT[0] + abortAt);
      check("R9 no done on abort", doneSeen, 0);
      check("R9 error flag set", int'(timeoutErr), 1);
      check("R1 tck low after abort", int'(tck), 0);
      return;
    end
    check(adp ? "R5 rise count" : "R3 rise count", nRise, n);
    for (int i = 0; i < n; i++) begin
      if (adp) begin
        expR = (i == 0) ? e0 + g : fallT[i-1] + ha;
        expF = riseT[i] + ha;
        check("R5 rise time", riseT[i], expR);
        check("R5 fall time", fallT[i], expF);
      end else begin
        check("R3 rise time", riseT[i], e0 + h * (2 * i + 1));
        check("R3 fall time", fallT[i], e0 + 2 * h * (i + 1));
      end
      check("R6 tms at rise", int'(capTms[i]), int'(pt[i]));
      check("R6 tdi at rise", int'(capTdi[i]), int'(pd[i]));
    end
    mask = (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    check("R7 captured tdo", int'(tdoBits), int'(32'(tdoPat) & mask));
    check("R8 single done pulse", doneSeen, 1);
    check("R8 done at last fall", doneT, fallT[n-1]);
    check(adp ? "R9 no error" : "R3 timeout ignored", int'(timeoutErr), 0);
  endtask

  task automatic ignoredReq(input int cnt);
    @(negedge clk);
    reqValid = 1'b1; reqCount = CNT_W'(cnt);
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check("R2 out-of-range count ignored", int'(busy), 0);
      check("R1 tck idle low", int'(tck), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset tck", int'(tck), 0);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset done", int'(done), 0);
    check("R1 reset error", int'(timeoutErr), 0);
    check("R1 reset tms", int'(tms), 0);
    check("R1 reset tdi", int'(tdi), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    ignoredReq(0);
    ignoredReq(MAX_BITS + 1);

    // fixed-mode sweep with rtck stuck high and a tiny timeout
    for (int hp = 0; hp <= 3; hp++)
      foreach (riseT[j]) if (j < 4) begin
        int n;
        n = (j == 0) ? 1 : (j == 1) ? 2 : (j == 2) ? 5 : MAX_BITS;
        runXfer(1'b0, hp, 0, 1, 1, n, hp * 10 + j, (j == 2), 0);
      end

    // adaptive sweep: timeout at the first passing value echo+2
    for (int gap = 0; gap <= 3; gap++)
      for (int echo = 1; echo <= 3; echo++)
        for (int j = 0; j < 3; j++) begin
          int n;
          n = (j == 0) ? 1 : (j == 1) ? 3 : MAX_BITS;
          runXfer(1'b1, 5, gap, echo, echo + 2, n, 100 + gap * 9 + echo * 3 + j, 1'b0, 0);
        end

    // timeout boundary: limit echo+1 must abort in the first high phase
    for (int echo = 1; echo <= 3; echo++) begin
      runXfer(1'b1, 5, 2, echo, echo + 1, 4, 300 + echo, 1'b0, echo + 1);
      runXfer(1'b1, 5, 1, echo, 0, 2, 310 + echo, 1'b0, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule